// File: doc/BRIEF.md
# Configuration Request Engine

This block issues single-dword configuration read and write requests on behalf of software toward one of two root ports. Software programs three header words and, for writes, one data word through a small register window. It then writes 1 to the start bit of the control register. The engine works out which root port serves the request from the bus and device numbers in header word 2 and from the two link-up flags. It patches the requester port field and the dword alignment into the outgoing header, and hands the request to the link layer on a valid/ready channel.

Software polls the start bit, which reads 1 while the request is outstanding and returns to 0 when the request finishes. A finished read leaves its completion data in the read-data register. That register is preset to all ones whenever a read starts, so a refused or timed-out read reads back as all ones. A request with no legal route is never sent and raises a sticky "rejected" flag. A request that gets no completion within `TIMEOUT_CYCLES` clock cycles is abandoned and raises a sticky "timeout" flag.

Back-pressure rules:
- The request channel holds `req_valid` and every payload signal steady until `req_ready` is seen high at a clock edge. The only exception is the timeout, which may withdraw the request.
- The completion channel accepts `cpl_valid` only while `cpl_ready` is high. `cpl_ready` is high only after the request has been handed over. A completion presented at any other time is ignored.

Top module: `cfg_req_engine`

## Requirements
- R1: After reset, the control register (offset 0x488) reads 0, the read-data register (0x48C) reads 0xFFFFFFFF, the header registers (0x460, 0x464, 0x468) and write data (0x470) read 0, and `req_valid` and `cpl_ready` are low.
- R2: Routing uses bus = header word 2 bits [31:24] and device = bits [23:19]. Bus 0 with device 0 or 1 goes to port 0 or 1 respectively. Bus 1 device 0 goes to port 0 only if `link_up[0]` is 1. Bus 2 device 0 goes to port 1 only if `link_up[1]` is 1. The chosen port appears on `req_port`.
- R3: `req_hdr1` equals the stored header word 1 with bits [20:19] replaced by the routed port number.
- R4: `req_hdr2` equals the stored header word 2 with bits [1:0] forced to 0; `req_hdr0` equals the stored header word 0.
- R5: A start (a write to 0x488 with bit 0 set, while idle) makes control bit 0 read 1 from the next cycle. Bit 0 returns to 0 the cycle after the completion is accepted.
- R6: A read (header word 0 bit 30 = 0) sets the read-data register to 0xFFFFFFFF on start. On completion it loads `cpl_data` into that register.
- R7: A write (header word 0 bit 30 = 1) sends the write-data register on `req_data` and leaves the read-data register unchanged.
- R8: If no completion is accepted within `TIMEOUT_CYCLES` cycles of the start, the request is dropped and busy clears. Control bit 1 (timeout) is then set, and a read leaves 0xFFFFFFFF in the read-data register.
- R9: A start with no legal route sends no request, leaves busy at 0, and sets control bit 2 (rejected).
- R10: While busy, a further start and writes to header and write-data registers are ignored.
- R11: `req_valid` with its payload holds steady until `req_ready` is seen. `cpl_ready` is high only while waiting for the completion.
- R12: Every start accepted while idle clears control bits 1 and 2 before its own outcome is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 12 | Register byte offset |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data (combinational on `csr_addr`) |
| link_up | input | 2 | Per-port link-up flags |
| req_valid | output | 1 | Request valid toward link layer |
| req_ready | input | 1 | Link layer accepts request |
| req_port | output | 1 | Root port serving the request |
| req_hdr0 | output | 32 | Header word 0 |
| req_hdr1 | output | 32 | Header word 1 with requester port patched |
| req_hdr2 | output | 32 | Header word 2, dword aligned |
| req_data | output | 32 | Write payload |
| cpl_valid | input | 1 | Completion valid |
| cpl_ready | output | 1 | Engine waiting for completion |
| cpl_data | input | 32 | Completion read data |

## Verification
The routing is exercised with every bus/device class:
- bus 0 with devices 0, 1 and 2;
- buses 1 and 2 with link-up both clear and set;
- bus 3.

This separates the direct root-port decode from the link-gated downstream decode and from rejection. Reads and writes alternate, so the read-data preset, the captured completion and the unchanged value after a write are each visible.

A scoreboard compares every request that leaves the engine against the expected port and patched headers. The link model also:
- stalls `req_ready` to expose unstable payloads;
- withholds completions to force the timeout;
- delays a completion long enough to test that writes and a second start are locked out while busy.

// File: rtl/cfg_tlp_pkg.sv
package cfg_tlp_pkg;
  localparam int unsigned CSR_AW = 12;
  localparam logic [CSR_AW-1:0] OFF_HDR0 = 12'h460;
  localparam logic [CSR_AW-1:0] OFF_HDR1 = 12'h464;
  localparam logic [CSR_AW-1:0] OFF_HDR2 = 12'h468;
  localparam logic [CSR_AW-1:0] OFF_WDAT = 12'h470;
  localparam logic [CSR_AW-1:0] OFF_CTRL = 12'h488;
  localparam logic [CSR_AW-1:0] OFF_RDAT = 12'h48C;
  localparam int unsigned PORT_LSB = 19;
  localparam int unsigned WRITE_BIT = 30;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } eng_state_t;
endpackage

// File: rtl/cfg_port_router.sv
module cfg_port_router (
  input  logic [7:0] bus_num,
  input  logic [4:0] dev_num,
  input  logic [1:0] link_up,
  output logic       route_ok,
  output logic       route_port
);
  always_comb begin
    route_ok   = 1'b0;
    route_port = 1'b0;
    if (bus_num == 8'd0 && dev_num < 5'd2) begin
      route_ok   = 1'b1;
      route_port = dev_num[0];
    end else if (bus_num == 8'd1 && dev_num == 5'd0 && link_up[0]) begin
      route_ok   = 1'b1;
      route_port = 1'b0;
    end else if (bus_num == 8'd2 && dev_num == 5'd0 && link_up[1]) begin
      route_ok   = 1'b1;
      route_port = 1'b1;
    end
  end

  // R2: only buses 0..2 can ever be routed
  always_comb begin
    p_route_bus_r2: assert (!route_ok || bus_num <= 8'd2);
  end
endmodule

// File: rtl/cfg_csr_bank.sv
module cfg_csr_bank
  import cfg_tlp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CSR_AW-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              busy,
  input  logic              tmo_flag,
  input  logic              rej_flag,
  input  logic [31:0]       rd_word,
  input  logic              port_q,
  output logic [31:0]       rdata,
  output logic [31:0]       hdr0_q,
  output logic [31:0]       hdr2_q,
  output logic [31:0]       hdr1_out,
  output logic [31:0]       hdr2_out,
  output logic [31:0]       wdat_q
);
  localparam logic [31:0] PORT_MASK = 32'h3 << PORT_LSB;

  logic [31:0] hdr1_q;
  logic        wr_ok;

  assign wr_ok = we && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hdr0_q <= '0;
      hdr1_q <= '0;
      hdr2_q <= '0;
      wdat_q <= '0;
    end else if (wr_ok) begin
      case (addr)
        OFF_HDR0: hdr0_q <= wdata;
        OFF_HDR1: hdr1_q <= wdata;
        OFF_HDR2: hdr2_q <= wdata;
        OFF_WDAT: wdat_q <= wdata;
        default: ;
      endcase
    end
  end

  assign hdr1_out = (hdr1_q & ~PORT_MASK) | (32'(port_q) << PORT_LSB);
  assign hdr2_out = {hdr2_q[31:2], 2'b00};

  always_comb begin
    case (addr)
      OFF_HDR0: rdata = hdr0_q;
      OFF_HDR1: rdata = hdr1_q;
      OFF_HDR2: rdata = hdr2_q;
      OFF_WDAT: rdata = wdat_q;
      OFF_CTRL: rdata = {29'd0, rej_flag, tmo_flag, busy};
      OFF_RDAT: rdata = rd_word;
      default:  rdata = '0;
    endcase
  end

  p_hdr_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(hdr0_q) && $stable(hdr1_q) && $stable(hdr2_q) && $stable(wdat_q)));
endmodule

// File: rtl/cfg_req_fsm.sv
module cfg_req_fsm
  import cfg_tlp_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYCLES = 2000000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        is_write,
  input  logic        route_ok,
  input  logic        route_port,
  input  logic        req_ready,
  input  logic        cpl_valid,
  input  logic [31:0] cpl_data,
  output logic        busy,
  output logic        req_valid,
  output logic        cpl_ready,
  output logic        port_q,
  output logic        tmo_flag,
  output logic        rej_flag,
  output logic [31:0] rd_word
);
  localparam int unsigned CNT_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYCLES - 1);

  eng_state_t       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             write_q;
  logic             last;
  logic             cpl_take;

  assign busy      = (state_q != ST_IDLE);
  assign req_valid = (state_q == ST_SEND);
  assign cpl_ready = (state_q == ST_WAIT);
  assign last      = (cnt_q == CNT_LAST);
  assign cpl_take  = cpl_ready && cpl_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      write_q  <= 1'b0;
      port_q   <= 1'b0;
      tmo_flag <= 1'b0;
      rej_flag <= 1'b0;
      rd_word  <= '1;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          tmo_flag <= 1'b0;
          rej_flag <= 1'b0;
          if (!is_write) rd_word <= '1;
          if (route_ok) begin
            state_q <= ST_SEND;
            port_q  <= route_port;
            write_q <= is_write;
            cnt_q   <= '0;
          end else begin
            rej_flag <= 1'b1;
          end
        end
        ST_SEND: begin
          if (last) begin
            state_q  <= ST_IDLE;
            tmo_flag <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
            if (req_ready) state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (cpl_valid) begin
            state_q <= ST_IDLE;
            if (!write_q) rd_word <= cpl_data;
          end else if (last) begin
            state_q  <= ST_IDLE;
            tmo_flag <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_valid_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !last) |=> (req_valid && $stable(port_q)));
  p_tmo_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && last && !cpl_take) |=> (!busy && tmo_flag));
  p_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_take |=> (!busy && !tmo_flag));
  p_read_preset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !is_write) |=> (rd_word == 32'hFFFF_FFFF));
  p_reject_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !route_ok) |=> (!busy && rej_flag && !tmo_flag));
  p_restart_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !last && !cpl_take) |=> (busy && cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/cfg_req_engine.sv
module cfg_req_engine
  import cfg_tlp_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYCLES = 2000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic [31:0]       csr_wdata,
  output logic [31:0]       csr_rdata,
  input  logic [1:0]        link_up,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_port,
  output logic [31:0]       req_hdr0,
  output logic [31:0]       req_hdr1,
  output logic [31:0]       req_hdr2,
  output logic [31:0]       req_data,
  input  logic              cpl_valid,
  output logic              cpl_ready,
  input  logic [31:0]       cpl_data
);
  logic        busy, tmo_flag, rej_flag, port_q;
  logic        route_ok, route_port, start;
  logic [31:0] rd_word, hdr0_q, hdr2_q;

  assign start = csr_we && (csr_addr == OFF_CTRL) && csr_wdata[0];

  cfg_csr_bank u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (csr_we),
    .addr     (csr_addr),
    .wdata    (csr_wdata),
    .busy     (busy),
    .tmo_flag (tmo_flag),
    .rej_flag (rej_flag),
    .rd_word  (rd_word),
    .port_q   (port_q),
    .rdata    (csr_rdata),
    .hdr0_q   (hdr0_q),
    .hdr2_q   (hdr2_q),
    .hdr1_out (req_hdr1),
    .hdr2_out (req_hdr2),
    .wdat_q   (req_data)
  );

  cfg_port_router u_router (
    .bus_num    (hdr2_q[31:24]),
    .dev_num    (hdr2_q[23:19]),
    .link_up    (link_up),
    .route_ok   (route_ok),
    .route_port (route_port)
  );

  cfg_req_fsm #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .is_write   (hdr0_q[WRITE_BIT]),
    .route_ok   (route_ok),
    .route_port (route_port),
    .req_ready  (req_ready),
    .cpl_valid  (cpl_valid),
    .cpl_data   (cpl_data),
    .busy       (busy),
    .req_valid  (req_valid),
    .cpl_ready  (cpl_ready),
    .port_q     (port_q),
    .tmo_flag   (tmo_flag),
    .rej_flag   (rej_flag),
    .rd_word    (rd_word)
  );

  assign req_hdr0 = hdr0_q;
  assign req_port = port_q;
endmodule

// File: tb/test_cfg_req_engine.sv
`timescale 1ns/1ps
module test_cfg_req_engine;
  localparam int TMO = 40;
  localparam logic [11:0] A_H0 = 12'h460, A_H1 = 12'h464, A_H2 = 12'h468,
                          A_WD = 12'h470, A_CT = 12'h488, A_RD = 12'h48C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        csr_we = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic [1:0]  link_up = 2'b00;
  logic        req_valid, req_port, cpl_ready;
  logic        req_ready = 1'b0;
  logic        cpl_valid = 1'b0;
  logic [31:0] cpl_data = '0;
  logic [31:0] req_hdr0, req_hdr1, req_hdr2, req_data;

  cfg_req_engine #(.TIMEOUT_CYCLES(TMO)) i_cfg_req_engine (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .link_up(link_up),
    .req_valid(req_valid), .req_ready(req_ready), .req_port(req_port),
    .req_hdr0(req_hdr0), .req_hdr1(req_hdr1), .req_hdr2(req_hdr2),
    .req_data(req_data), .cpl_valid(cpl_valid), .cpl_ready(cpl_ready),
    .cpl_data(cpl_data)
  );

  typedef struct packed {
    logic        port;
    logic [31:0] h0, h1, h2, d;
  } exp_t;
  exp_t exp_q[$];

  int errs = 0;
  int checks = 0;
  bit respond = 1'b1;
  bit hold_ready = 1'b0;
  int lat = 2;
  logic [31:0] resp_val = '0;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // link model and scoreboard monitor
  initial begin
    bit pend = 1'b0;
    int wc = 0;
    exp_t e;
    forever begin
      @(negedge clk);
      if (req_ready) begin
        req_ready = 1'b0;
        if (respond) begin pend = 1'b1; wc = lat; end
      end else if (req_valid && !hold_ready) begin
        if (exp_q.size() == 0) begin
          checks++; errs++;
          $display("FAIL R10 unexpected request: actual=%h expected=none", req_hdr2);
        end else begin
          e = exp_q.pop_front();
          check("R2", "port", 32'(req_port), 32'(e.port));
          check("R4", "hdr0", req_hdr0, e.h0);
          check("R3", "hdr1", req_hdr1, e.h1);
          check("R4", "hdr2", req_hdr2, e.h2);
          if (e.h0[30]) check("R7", "data", req_data, e.d);
        end
        req_ready = 1'b1;
      end
      if (cpl_valid) cpl_valid = 1'b0;
      else if (pend) begin
        if (wc == 0) begin cpl_valid = 1'b1; cpl_data = resp_val; pend = 1'b0; end
        else wc--;
      end
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    csr_addr = a;
    #1 v = csr_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 400; i++) begin
      rd(A_CT, v);
      if (!v[0]) break;
    end
  endtask

  task automatic issue(logic [7:0] bus, logic [4:0] dev, logic [11:0] rg, bit is_wr,
                       logic [31:0] d, bit ok, bit port);
    logic [31:0] h0, h1, h2;
    exp_t e;
    h0 = is_wr ? 32'h4400_0001 : 32'h0400_0001;
    h1 = 32'h0000_070F;
    h2 = {bus, dev, 3'd1, 4'd0, rg};
    wr(A_H0, h0); wr(A_H1, h1); wr(A_H2, h2); wr(A_WD, d);
    if (ok) begin
      e.port = port; e.h0 = h0; e.h1 = h1 | (32'(port) << 19);
      e.h2 = {h2[31:2], 2'b00}; e.d = d;
      exp_q.push_back(e);
    end
    wr(A_CT, 32'h1);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; errs++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(A_CT, v); check("R1", "ctrl", v, 32'h0);
    rd(A_RD, v); check("R1", "rdat", v, 32'hFFFF_FFFF);
    rd(A_H2, v); check("R1", "hdr2", v, 32'h0);
    check("R1", "req_valid", 32'(req_valid), 32'h0);
    check("R1", "cpl_ready", 32'(cpl_ready), 32'h0);

    // R2 R3 R4 R5 R6: read on bus 0 device 0, unaligned offset
    resp_val = 32'h1234_5678;
    issue(8'd0, 5'd0, 12'h013, 1'b0, 32'h0, 1'b1, 1'b0);
    rd(A_CT, v); check("R5", "busy set", 32'(v[0]), 32'h1);
    wait_idle();
    rd(A_CT, v); check("R5", "ctrl after done", v, 32'h0);
    rd(A_RD, v); check("R6", "read data", v, 32'h1234_5678);

    // R7: write on bus 0 device 1
    issue(8'd0, 5'd1, 12'h044, 1'b1, 32'hCAFE_F00D, 1'b1, 1'b1);
    wait_idle();
    rd(A_RD, v); check("R7", "rdat kept", v, 32'h1234_5678);

    // R9: bus 1 without link
    issue(8'd1, 5'd0, 12'h000, 1'b0, 32'h0, 1'b0, 1'b0);
    rd(A_CT, v); check("R9", "rejected", v, 32'h4);
    rd(A_RD, v); check("R9", "rdat ones", v, 32'hFFFF_FFFF);

    // R2 R12: link-gated buses
    link_up = 2'b11;
    resp_val = 32'h0000_00AA;
    issue(8'd1, 5'd0, 12'h100, 1'b0, 32'h0, 1'b1, 1'b0);
    wait_idle();
    rd(A_CT, v); check("R12", "flags cleared", v, 32'h0);
    rd(A_RD, v); check("R2", "bus1 read", v, 32'h0000_00AA);
    resp_val = 32'h0000_00BB;
    issue(8'd2, 5'd0, 12'h104, 1'b0, 32'h0, 1'b1, 1'b1);
    wait_idle();
    rd(A_RD, v); check("R2", "bus2 read", v, 32'h0000_00BB);

    // R2 R9: illegal routes
    link_up = 2'b01;
    issue(8'd2, 5'd0, 12'h0, 1'b0, 32'h0, 1'b0, 1'b0);
    rd(A_CT, v); check("R9", "bus2 no link", v, 32'h4);
    issue(8'd0, 5'd2, 12'h0, 1'b1, 32'h5, 1'b0, 1'b0);
    rd(A_CT, v); check("R9", "bus0 dev2", v, 32'h4);
    issue(8'd3, 5'd0, 12'h0, 1'b0, 32'h0, 1'b0, 1'b0);
    rd(A_CT, v); check("R9", "bus3", v, 32'h4);

    // R8: no completion
    respond = 1'b0;
    issue(8'd0, 5'd0, 12'h008, 1'b0, 32'h0, 1'b1, 1'b0);
    rd(A_CT, v); check("R8", "busy during wait", 32'(v[0]), 32'h1);
    repeat (TMO) @(negedge clk);
    rd(A_CT, v); check("R8", "timeout flag", v, 32'h2);
    rd(A_RD, v); check("R8", "rdat ones", v, 32'hFFFF_FFFF);
    respond = 1'b1;
    resp_val = 32'h0BAD_CAFE;
    issue(8'd0, 5'd1, 12'h00C, 1'b0, 32'h0, 1'b1, 1'b1);
    wait_idle();
    rd(A_CT, v); check("R12", "timeout cleared", v, 32'h0);

    // R11: back-pressure
    hold_ready = 1'b1;
    issue(8'd0, 5'd0, 12'h020, 1'b1, 32'h1357_9BDF, 1'b1, 1'b0);
    repeat (5) @(negedge clk);
    check("R11", "valid held", 32'(req_valid), 32'h1);
    check("R11", "data held", req_data, 32'h1357_9BDF);
    check("R11", "cpl_ready low in send", 32'(cpl_ready), 32'h0);
    hold_ready = 1'b0;
    wait_idle();
    check("R11", "cpl_ready idle", 32'(cpl_ready), 32'h0);

    // R10: lockout while busy
    lat = 15;
    resp_val = 32'h0000_0055;
    issue(8'd0, 5'd1, 12'h030, 1'b0, 32'h0, 1'b1, 1'b1);
    wr(A_H2, 32'hDEAD_BEEF);
    wr(A_CT, 32'h1);
    wait_idle();
    repeat (6) @(negedge clk);
    rd(A_H2, v); check("R10", "hdr2 locked", v, {8'd0, 5'd1, 3'd1, 4'd0, 12'h030});
    rd(A_RD, v); check("R10", "read data", v, 32'h0000_0055);
    rd(A_CT, v); check("R10", "idle after", v, 32'h0);
    lat = 2;
    finish_run();
  end
endmodule